// File: doc/BRIEF.md
# SPI Flash Command Transaction Engine

This block is a register-programmed SPI master that performs one serial-flash command each time software asks for it. Software fills an address/opcode register and a data register, writes the transmit and receive byte counts into the control register together with a start bit, and then polls a busy flag. The engine asserts the chosen chip select, shifts out between one and eight bytes, and then, with the select still held, shifts in up to eight bytes.

Bytes leave and arrive through fixed byte lanes of the two 32-bit registers. On transmit, the opcode goes first, then the address high byte to low byte, then the data register low byte to high byte. On receive, bytes fill the data register from its low byte upward and then spill into the address/opcode register, again from its low byte upward. A separate divider register picks one of four serial clock rates. The engine always uses 24-bit addressing and SPI mode 0, most significant bit first.

Top module: `spi_flash_xact`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, both chip selects are high, the serial clock is low, and the divider register (offset 0x1C) reads 0x00030000, which is rate code 3 in bits [17:16].
- R2: The address/opcode register (offset 0x04) and the data register (offset 0x08) read back what was written. The control fields read back in these bits: transmit count [3:0], receive count [7:4], select [9], address-size override [20:19].
- R3: Writing control bit 8 as 1 starts a transaction, and bit 8 always reads 0. A control write with bit 8 at 0 starts nothing.
- R4: Control bit 16 reads 1 from the cycle after the start write until the transaction's last serial clock falling edge, and reads 0 otherwise. Writes to bit 16 have no effect.
- R5: With bit 9 at 0, select 0 (`spi_cs_n[0]`) is driven low during a transaction and select 1 stays high. With bit 9 at 1 the two roles swap. At most one select is low at any time.
- R6: Transmit byte k = 0..7 is taken from: address/opcode [7:0], [31:24], [23:16], [15:8], then data [7:0], [15:8], [23:16], [31:24].
- R7: Receive byte k = 0..7 is stored into: data [7:0], [15:8], [23:16], [31:24], then address/opcode [7:0], [15:8], [23:16], [31:24].
- R8: The receive phase follows the transmit phase with no gap. The select stays low across both phases, and exactly 8*(transmit count + receive count) serial clock pulses occur.
- R9: SPI mode 0, most significant bit first. The serial clock idles low, MOSI changes only after a falling edge, and MISO is sampled on the rising edge.
- R10: Divider codes 0, 1, 2 and 3 give a serial clock period of 2, 4, 8 and 16 system clock cycles.
- R11: While busy, every register write is ignored, including a start request.
- R12: A transmit count of 0 is treated as 1. A transmit count above 8 is treated as 8, and so is a receive count above 8. The stored fields still read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_addr | input | ADDR_W | Byte offset of the register being written |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | ADDR_W | Byte offset of the register being read |
| reg_rd_data | output | 32 | Combinational read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
The hardest case to reach from the ports is a receive longer than four bytes. In that case the incoming data overwrites the address/opcode register whose bytes were transmitted earlier in the same transaction. The bench reaches it with a flash model that tracks serial-clock edges and returns a distinct byte at every receive position, so a lane swap or an off-by-one shows up as a wrong byte in one specific register lane. Register writes are also issued in the middle of a long, slow transaction, to show that neither the frozen registers nor the transfer itself change.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CNT_W   = 4;
  localparam int unsigned DIV_W   = 2;
  localparam int unsigned MAX_XB  = 8;
  localparam int unsigned LANE_W  = $clog2(MAX_XB);
  localparam int unsigned TOT_W   = $clog2(2 * MAX_XB) + 1;

  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_AOP  = 'h04;
  localparam int unsigned OFF_DATA = 'h08;
  localparam int unsigned OFF_DIV  = 'h1C;

  // Effective transmit count: 1..8
  function automatic logic [CNT_W-1:0] eff_tx(input logic [CNT_W-1:0] c);
    if (c == '0) return CNT_W'(1);
    if (c > CNT_W'(MAX_XB)) return CNT_W'(MAX_XB);
    return c;
  endfunction

  // Effective receive count: 0..8
  function automatic logic [CNT_W-1:0] eff_rx(input logic [CNT_W-1:0] c);
    if (c > CNT_W'(MAX_XB)) return CNT_W'(MAX_XB);
    return c;
  endfunction

  // Source lane for outgoing byte k
  function automatic logic [BYTE_W-1:0] tx_lane(input logic [REG_W-1:0] aop,
                                                input logic [REG_W-1:0] dat,
                                                input logic [LANE_W-1:0] k);
    logic [BYTE_W-1:0] b;
    case (k)
      3'd0:    b = aop[7:0];
      3'd1:    b = aop[31:24];
      3'd2:    b = aop[23:16];
      3'd3:    b = aop[15:8];
      3'd4:    b = dat[7:0];
      3'd5:    b = dat[15:8];
      3'd6:    b = dat[23:16];
      default: b = dat[31:24];
    endcase
    return b;
  endfunction

  // System clock cycles per serial clock half period
  function automatic int unsigned half_cycles(input logic [DIV_W-1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/spx_clkdiv.sv
module spx_clkdiv
  import spx_pkg::*;
#(
  parameter int unsigned HC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] code,
  output logic             tick
);
  logic [HC_W-1:0] cnt;
  logic [HC_W-1:0] lim;

  assign lim  = HC_W'(half_cycles(code) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + HC_W'(1);
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim); // R10
endmodule

// File: rtl/spx_shifter.sv
module spx_shifter
  import spx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  tx_req,
  input  logic [CNT_W-1:0]  rx_req,
  input  logic [REG_W-1:0]  aop,
  input  logic [REG_W-1:0]  dat,
  input  logic              tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              rx_we,
  output logic [LANE_W-1:0] rx_lane,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [CNT_W-1:0]  tx_n;
  logic [TOT_W-1:0]  tot_n;
  logic [TOT_W-1:0]  byte_idx;
  logic [TOT_W-1:0]  rx_pos;
  logic [2:0]        bit_idx;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] cur_tx;
  logic              rise_ev, fall_ev, in_rx, byte_end, xact_end;

  assign rise_ev  = busy && tick && !sclk;
  assign fall_ev  = busy && tick && sclk;
  assign in_rx    = byte_idx >= TOT_W'(tx_n);
  assign rx_pos   = byte_idx - TOT_W'(tx_n);
  assign byte_end = (bit_idx == 3'd0);
  assign xact_end = byte_end && (byte_idx == tot_n - TOT_W'(1));
  assign cur_tx   = tx_lane(aop, dat, byte_idx[LANE_W-1:0]);

  assign mosi    = busy && !in_rx && cur_tx[bit_idx];
  assign rx_we   = rise_ev && in_rx && byte_end;
  assign rx_byte = {rx_sh, miso};
  assign rx_lane = rx_pos[LANE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sclk     <= 1'b0;
      tx_n     <= '0;
      tot_n    <= '0;
      byte_idx <= '0;
      bit_idx  <= 3'd7;
      rx_sh    <= '0;
    end else if (!busy) begin
      sclk <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        tx_n     <= eff_tx(tx_req);
        tot_n    <= TOT_W'(eff_tx(tx_req)) + TOT_W'(eff_rx(rx_req));
        byte_idx <= '0;
        bit_idx  <= 3'd7;
      end
    end else if (rise_ev) begin
      sclk  <= 1'b1;
      rx_sh <= {rx_sh[BYTE_W-3:0], miso};
    end else if (fall_ev) begin
      sclk <= 1'b0;
      if (xact_end) begin
        busy <= 1'b0;
      end else if (byte_end) begin
        byte_idx <= byte_idx + TOT_W'(1);
        bit_idx  <= 3'd7;
      end else begin
        bit_idx <= bit_idx - 3'd1;
      end
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R4
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk); // R9
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sclk) |-> $stable(mosi)); // R9
  AST_BYTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_idx < tot_n)); // R8
endmodule

// File: rtl/spx_regfile.sv
module spx_regfile
  import spx_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              eng_busy,
  input  logic              rx_we,
  input  logic [LANE_W-1:0] rx_lane,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              start,
  output logic [CNT_W-1:0]  tx_cnt,
  output logic [CNT_W-1:0]  rx_cnt,
  output logic              cs_sel,
  output logic [DIV_W-1:0]  div_code,
  output logic [REG_W-1:0]  aop,
  output logic [REG_W-1:0]  dat
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_AOP  = ADDR_W'(OFF_AOP);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV);

  logic       busy_all;
  logic       wr_ok;
  logic [1:0] ovr;

  assign busy_all = eng_busy || start;
  assign wr_ok    = wr_en && !busy_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start    <= 1'b0;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      cs_sel   <= 1'b0;
      ovr      <= '0;
      div_code <= DIV_W'(3);
      aop      <= '0;
      dat      <= '0;
    end else begin
      start <= wr_ok && (wr_addr == A_CTRL) && wr_data[8];
      if (wr_ok && (wr_addr == A_CTRL)) begin
        tx_cnt <= wr_data[3:0];
        rx_cnt <= wr_data[7:4];
        cs_sel <= wr_data[9];
        ovr    <= wr_data[20:19];
      end
      if (wr_ok && (wr_addr == A_DIV)) div_code <= wr_data[17:16];
      if (wr_ok && (wr_addr == A_AOP)) aop <= wr_data;
      else if (rx_we && rx_lane[LANE_W-1]) aop[8*rx_lane[1:0] +: 8] <= rx_byte;
      if (wr_ok && (wr_addr == A_DATA)) dat <= wr_data;
      else if (rx_we && !rx_lane[LANE_W-1]) dat[8*rx_lane[1:0] +: 8] <= rx_byte;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {11'd0, ovr, 2'b00, busy_all, 6'd0, cs_sel, 1'b0, rx_cnt, tx_cnt};
      A_AOP:   rd_data = aop;
      A_DATA:  rd_data = dat;
      A_DIV:   rd_data = {14'd0, div_code, 16'd0};
      default: rd_data = '0;
    endcase
  end

  AST_AOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_all && !rx_we) |=> $stable(aop)); // R11
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_all |=> $stable(div_code)); // R11
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !start); // R11
endmodule

// File: rtl/spi_flash_xact.sv
module spi_flash_xact
  import spx_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned HC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [1:0]        spi_cs_n
);
  logic              start, busy, tick, cs_sel, rx_we;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DIV_W-1:0]  div_code;
  logic [REG_W-1:0]  aop, dat;
  logic [LANE_W-1:0] rx_lane;
  logic [BYTE_W-1:0] rx_byte;

  spx_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .eng_busy(busy), .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte),
    .start(start), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .cs_sel(cs_sel),
    .div_code(div_code), .aop(aop), .dat(dat)
  );

  spx_clkdiv #(.HC_W(HC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(div_code), .tick(tick)
  );

  spx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tx_req(tx_cnt), .rx_req(rx_cnt), .aop(aop), .dat(dat),
    .tick(tick), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(busy),
    .rx_we(rx_we), .rx_lane(rx_lane), .rx_byte(rx_byte)
  );

  assign spi_cs_n[0] = !(busy && !cs_sel);
  assign spi_cs_n[1] = !(busy && cs_sel);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R5
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spi_cs_n)); // R8
  AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n == 2'b11)); // R5
endmodule

// File: tb/spi_flash_xact_tb.sv
`timescale 1ns/1ps
module spi_flash_xact_tb;
  localparam int AW = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic sclk, mosi, miso = 1'b0;
  logic [1:0] cs_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_flash_xact #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  // flash model
  logic [7:0] sl [0:15];
  logic [7:0] got [0:15];
  logic [7:0] sh;
  int bitcnt;
  logic [1:0] cs_first;
  bit cs_var;
  realtime t_prev, per;

  function automatic logic sbit(input int n);
    if (n >= 128) return 1'b0;
    return sl[n/8][7-(n%8)];
  endfunction

  always @(posedge sclk) begin
    if (bitcnt == 0) cs_first = cs_n;
    else begin
      if (cs_n != cs_first) cs_var = 1;
      per = $realtime - t_prev;
    end
    t_prev = $realtime;
    sh = {sh[6:0], mosi};
    bitcnt++;
    if (bitcnt % 8 == 0 && bitcnt <= 128) got[bitcnt/8-1] = sh;
  end

  always @(negedge sclk) miso = sbit(bitcnt);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic prep_slave();
    for (int i = 0; i < 16; i++) begin sl[i] = 8'h00; got[i] = 8'hxx; end
  endtask

  task automatic begin_xact(input logic [31:0] ctrl);
    logic [31:0] v;
    bitcnt = 0; cs_var = 0; per = 0; cs_first = 2'b11;
    miso = sbit(0);
    wr(5'h00, ctrl | 32'h100);
    rd(5'h00, v);
    check(v[16] == 1'b1, "R4 busy after start", v, v | 32'h10000);
    check(v[8] == 1'b0, "R3 start reads 0", v, v & ~32'h100);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h00, v);
      if (!v[16]) break;
    end
    check(v[16] == 1'b0, "R4 busy clears", v, v & ~32'h10000);
    check(cs_n == 2'b11 && sclk == 1'b0, "R9 idle pins", {30'd0, cs_n}, 32'h3);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); check(v == 32'h0, "R1 ctrl reset", v, 32'h0);
    rd(5'h1C, v); check(v == 32'h00030000, "R1 div reset", v, 32'h00030000);
    check(cs_n == 2'b11 && sclk == 1'b0, "R1 pins idle", {30'd0, cs_n}, 32'h3);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'h04, 32'hA5C3_0F96); rd(5'h04, v); check(v == 32'hA5C30F96, "R2 aop rw", v, 32'hA5C30F96);
    wr(5'h08, 32'h1357_9BDF); rd(5'h08, v); check(v == 32'h13579BDF, "R2 data rw", v, 32'h13579BDF);
    wr(5'h00, 32'h0011_0281);
    repeat (4) @(negedge clk);
    check(cs_n == 2'b11, "R3 no start on bit8=0", {30'd0, cs_n}, 32'h3);
    rd(5'h00, v); check(v == 32'h00100281, "R2 ctrl fields R4 bit16 write ignored", v, 32'h00100281);
    wr(5'h1C, 32'h0001_0000); rd(5'h1C, v); check(v == 32'h00010000, "R2 div rw", v, 32'h00010000);
  endtask

  task automatic t_tx8();
    logic [7:0] exp [0:7];
    exp = '{8'h02, 8'h12, 8'h34, 8'h56, 8'hEF, 8'hBE, 8'hAD, 8'hDE};
    prep_slave();
    wr(5'h04, 32'h1234_5602); wr(5'h08, 32'hDEAD_BEEF); wr(5'h1C, 32'h0);
    begin_xact(32'h0000_0008);
    wait_idle();
    for (int k = 0; k < 8; k++)
      check(got[k] == exp[k], $sformatf("R6 R9 tx byte %0d", k), {24'd0, got[k]}, {24'd0, exp[k]});
    check(bitcnt == 64, "R8 pulse count tx8", bitcnt, 64);
    check(cs_first == 2'b10 && !cs_var, "R5 sel0 R8 held", {30'd0, cs_first}, 32'h2);
    check(per == 8.0, "R10 code0 period", int'(per), 8);
  endtask

  task automatic t_rx8();
    logic [31:0] v;
    prep_slave();
    for (int j = 0; j < 8; j++) sl[4 + j] = 8'hA1 + 8'(j);
    wr(5'h04, 32'h0000_0003); wr(5'h08, 32'h0); wr(5'h1C, 32'h0001_0000);
    begin_xact(32'h0000_0284);
    wait_idle();
    rd(5'h08, v); check(v == 32'hA4A3A2A1, "R7 rx lanes data", v, 32'hA4A3A2A1);
    rd(5'h04, v); check(v == 32'hA8A7A6A5, "R7 rx spill aop", v, 32'hA8A7A6A5);
    check(bitcnt == 96, "R8 pulse count tx4 rx8", bitcnt, 96);
    check(cs_first == 2'b01 && !cs_var, "R5 sel1 R8 held", {30'd0, cs_first}, 32'h1);
    check(per == 16.0, "R10 code1 period", int'(per), 16);
  endtask

  task automatic t_div(input logic [1:0] code);
    prep_slave();
    wr(5'h1C, {14'd0, code, 16'd0});
    begin_xact(32'h0000_0001);
    wait_idle();
    check(per == real'(8 << code), $sformatf("R10 code%0d period", code), int'(per), 8 << code);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    prep_slave();
    wr(5'h04, 32'h5566_7788); wr(5'h08, 32'h99AA_BBCC); wr(5'h1C, 32'h0003_0000);
    begin_xact(32'h0000_0002);
    repeat (20) @(negedge clk);
    wr(5'h04, 32'hFFFF_FFFF); wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0000_03FF); wr(5'h1C, 32'h0);
    wait_idle();
    repeat (40) @(negedge clk);
    check(cs_n == 2'b11, "R11 no restart", {30'd0, cs_n}, 32'h3);
    check(bitcnt == 16, "R11 single transfer", bitcnt, 16);
    rd(5'h04, v); check(v == 32'h55667788, "R11 aop kept", v, 32'h55667788);
    rd(5'h08, v); check(v == 32'h99AABBCC, "R11 data kept", v, 32'h99AABBCC);
    rd(5'h00, v); check(v == 32'h00000002, "R11 ctrl kept", v, 32'h2);
    rd(5'h1C, v); check(v == 32'h00030000, "R11 div kept", v, 32'h00030000);
    check(got[0] == 8'h88 && got[1] == 8'h55, "R11 tx unchanged", {got[1], got[0]}, 32'h5588);
  endtask

  task automatic t_clamp();
    logic [31:0] v;
    prep_slave();
    wr(5'h1C, 32'h0);
    begin_xact(32'h0000_0000); wait_idle();
    check(bitcnt == 8, "R12 tx0 as 1", bitcnt, 8);
    begin_xact(32'h0000_000F); wait_idle();
    check(bitcnt == 64, "R12 tx15 as 8", bitcnt, 64);
    for (int j = 0; j < 8; j++) sl[1 + j] = 8'h30 + 8'(j);
    begin_xact(32'h0000_00C1); wait_idle();
    check(bitcnt == 72, "R12 rx12 as 8", bitcnt, 72);
    rd(5'h08, v); check(v == 32'h33323130, "R12 R7 data lanes", v, 32'h33323130);
    rd(5'h04, v); check(v == 32'h37363534, "R12 R7 aop lanes", v, 32'h37363534);
    rd(5'h00, v); check(v == 32'h000000C1, "R12 raw fields", v, 32'hC1);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    prep_slave();
    bitcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_tx8();
    t_rx8();
    t_div(2'd3);
    t_div(2'd2);
    t_busy_ignore();
    t_clamp();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule